// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a synchronous static memory with a small internal array, built for a pipeline in which every access, read or write, has its data phase exactly two rising clock edges after its command. Address and control are registered on one edge and move through two command stages. On the second edge after the command, write data is taken from the data input and stored, or read data is loaded into the output register. Because reads and writes share the same latency, a stream of mixed reads and writes runs back to back with no idle bus cycles between them.

The data word is split into four 9-bit byte lanes, and each lane has its own active-low write enable. Three chip enables of mixed polarity select the block for a new access. A load/advance control chooses between starting a fresh access and continuing the operation kind already running, using the address that a separate sequencing block presents. A clock enable and a sleep input each freeze the whole pipeline. An asynchronous output enable masks only the drive-enable output.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled on edge N loads the addressed word onto `dout` at edge N+2, and `dout_en` is high from then until edge N+3, provided `oe_n` is low.
- R2: While `cken_n` is sampled high, an edge changes nothing: the command stages, the array, `dout` and `dout_en` all keep their values.
- R3: A new access starts only on an edge where `ld_n` is low and all three chip enables are true (`cs1_n`=0, `cs2_n`=0, `cs3`=1); if any of them is false, that edge issues a deselect and the array is not written.
- R4: A deselect does not cancel accesses already in flight: a read issued in the cycle before a deselect still returns its data.
- R5: Two edges after a write, a deselect or an idle advance is sampled, `dout_en` goes low.
- R6: Lane k is `din`/`dout` bits [9k+8:9k]. Lane k is written only when `bwe_n[k]` was low with the write command, and any combination of lanes may be written. The data stored is `din` as sampled on the data edge, two edges after the command.
- R7: Byte write enables have no effect on read commands: the array is unchanged after a read, whatever the value of `bwe_n`.
- R8: `oe_n` high forces `dout_en` low at once, without waiting for a clock edge, and never stalls the pipeline.
- R9: After the first rising edge with `rst_n` low, `dout_en` is low, and no access is in flight.
- R10: A read issued on the edge right after a write to the same address returns the newly written bytes.
- R11: While `sleep` is high, each edge behaves as if `cken_n` were high, and the array contents are kept.
- R12: With `ld_n` high, a new access of the same kind (read or write) as the most recent loaded access is issued at the present `addr`, and `wr_n` and the chip enables are ignored; after a deselect or reset, an advance issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | High freezes all activity |
| cken_n | input | 1 | Active-low clock enable |
| ld_n | input | 1 | Low: load new access; high: advance |
| wr_n | input | 1 | Low: write, high: read (load cycles only) |
| cs1_n | input | 1 | Active-low chip enable |
| cs2_n | input | 1 | Second active-low chip enable |
| cs3 | input | 1 | Active-high chip enable |
| addr | input | ADDR_W (6) | Word address |
| bwe_n | input | LANES (4) | Active-low per-lane write enables |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W (36) | Write data, sampled on the data edge |
| dout | output | LANES*LANE_W (36) | Registered read data |
| dout_en | output | 1 | High when `dout` should drive the bus |

## Verification
The assertions assume that every control input is a known 0 or 1 on each edge once reset is released, and that `rst_n` is only released after at least one edge so the command stages start empty. The stimulus changes all inputs on falling edges only, never leaves a control input undriven, reads an address only after the first sweep has written it, and supplies write data on the data edge from the bench's own record of the commands in flight, so the assertions always see settled and defined values.

// File: rtl/zbt_pkg.sv
// Shared types for the zero-turnaround SRAM.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package zbt_pkg;

    // Kind of access held in a command stage.
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zbt_ctrl_pipe.sv
// Command decode and two-stage command pipeline.
// Decodes load/advance and chip enables into an access kind, keeps the
// kind of the last loaded access for advance cycles, and carries the
// kind, address and byte enables two edges down to the data phase.
// Assumes: go is low whenever the clock edge must be ignored.
module zbt_ctrl_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              ld_n,
    input  logic              wr_n,
    input  logic              cs1_n,
    input  logic              cs2_n,
    input  logic              cs3,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bwe_n,
    output op_e               op_dp,
    output logic [ADDR_W-1:0] addr_dp,
    output logic [LANES-1:0]  bwe_dp
);

    logic              sel;
    op_e               issue;
    op_e               op_s1;
    logic [ADDR_W-1:0] addr_s1;
    logic [LANES-1:0]  bwe_s1;
    logic              live;
    logic              live_wr;

    assign sel = !cs1_n && !cs2_n && cs3;

    // Decide which access, if any, this edge starts.
    always_comb begin
        issue = OP_NONE;
        if (!ld_n) begin
            if (sel) issue = wr_n ? OP_READ : OP_WRITE;
        end else if (live) begin
            issue = live_wr ? OP_WRITE : OP_READ;
        end
    end

    // Advance both command stages and track the running access kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_s1   <= OP_NONE;
            op_dp   <= OP_NONE;
            addr_s1 <= '0;
            addr_dp <= '0;
            bwe_s1  <= '1;
            bwe_dp  <= '1;
            live    <= 1'b0;
            live_wr <= 1'b0;
        end else if (go) begin
            op_s1   <= issue;
            addr_s1 <= addr;
            bwe_s1  <= bwe_n;
            op_dp   <= op_s1;
            addr_dp <= addr_s1;
            bwe_dp  <= bwe_s1;
            if (!ld_n) begin
                live <= sel;
                if (sel) live_wr <= !wr_n;
            end
        end
    end

    AST_STALL_FREEZES_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> ($stable(op_s1) && $stable(op_dp) && $stable(addr_dp))); // R2
    AST_DESELECT_STARTS_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ld_n && !sel) |=> (op_s1 == OP_NONE)); // R3
    AST_INFLIGHT_PROCEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ld_n && !sel && op_s1 == OP_READ) |=> (op_dp == OP_READ)); // R4

endmodule

// File: rtl/zbt_lane_array.sv
// Storage array split into byte lanes, with the registered read port.
// On the data edge a write stores each enabled lane of din, and a read
// loads the addressed word into the output register.
// Assumes: op_dp/addr_dp/bwe_dp describe the access whose data edge is now.
module zbt_lane_array
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  op_e                     op_dp,
    input  logic [ADDR_W-1:0]       addr_dp,
    input  logic [LANES-1:0]        bwe_dp,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rd_q
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane on a write data edge when its enable was low.
        always_ff @(posedge clk) begin
            if (go && op_dp == OP_WRITE && !bwe_dp[k])
                mem[addr_dp] <= din[k*LANE_W +: LANE_W];
        end

        // Load this lane of the output register on a read data edge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rd_q[k*LANE_W +: LANE_W] <= '0;
            else if (go && op_dp == OP_READ)
                rd_q[k*LANE_W +: LANE_W] <= mem[addr_dp];
        end
    end

    AST_READ_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!go || op_dp != OP_READ) |=> $stable(rd_q)); // R2

endmodule

// File: rtl/zbt_drive.sv
// Output drive state.
// Records whether the data edge just taken was a read, and masks the
// result with the asynchronous output enable.
// Assumes: oe_n may change at any time, independent of clk.
module zbt_drive
    import zbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  op_e  op_dp,
    input  logic oe_n,
    output logic dout_en
);

    logic drv_q;

    // Drive after a read data edge, release after any other data edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drv_q <= 1'b0;
        else if (go)
            drv_q <= (op_dp == OP_READ);
    end

    assign dout_en = drv_q && !oe_n;

    AST_READ_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_dp == OP_READ && !oe_n) |=> (dout_en || oe_n)); // R1
    AST_RELEASE_AFTER_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_dp != OP_READ) |=> !dout_en); // R5
    AST_STALL_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(drv_q)); // R2

endmodule

// File: rtl/zbt_sram.sv
// Top of the zero-turnaround pipelined SRAM.
// Every access has its data phase two rising edges after its command;
// clock enable and sleep freeze the whole pipeline.
// Assumes: synchronous inputs are stable around the rising clock edge.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    cken_n,
    input  logic                    ld_n,
    input  logic                    wr_n,
    input  logic                    cs1_n,
    input  logic                    cs2_n,
    input  logic                    cs3,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        bwe_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);

    logic              go;
    op_e               op_dp;
    logic [ADDR_W-1:0] addr_dp;
    logic [LANES-1:0]  bwe_dp;

    // An edge counts only when clock enable is low and sleep is off.
    assign go = !cken_n && !sleep;

    zbt_ctrl_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .go(go), .ld_n(ld_n), .wr_n(wr_n),
        .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3), .addr(addr),
        .bwe_n(bwe_n), .op_dp(op_dp), .addr_dp(addr_dp), .bwe_dp(bwe_dp)
    );

    zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .go(go), .op_dp(op_dp),
        .addr_dp(addr_dp), .bwe_dp(bwe_dp), .din(din), .rd_q(dout)
    );

    zbt_drive u_drive (
        .clk(clk), .rst_n(rst_n), .go(go), .op_dp(op_dp),
        .oe_n(oe_n), .dout_en(dout_en)
    );

    AST_SLEEP_FREEZES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> ($stable(dout) && $stable(dout_en || oe_n))); // R11

endmodule

// File: tb/zbt_sram_test.sv
`timescale 1ns/1ps
module zbt_sram_test;

    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0;
    logic          cken_n = 1'b0;
    logic          ld_n = 1'b0;
    logic          wr_n = 1'b1;
    logic          cs1_n = 1'b1;
    logic          cs2_n = 1'b0;
    logic          cs3 = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bwe_n = '1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int bad = 0;
    int cyc = 0;

    // Bench model state, built from the requirements.
    logic [DW-1:0] mm [1<<AW];
    int            m1op = 0, m2op = 0;   // 0 none, 1 read, 2 write
    logic [AW-1:0] m1a = '0, m2a = '0;
    logic [NL-1:0] m1b = '1, m2b = '1;
    logic [DW-1:0] m1d = '0, m2d = '0;
    bit            live = 0, lwr = 0;
    bit            exp_drv = 0;
    logic [DW-1:0] exp_dat = '0;

    zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .cken_n(cken_n),
        .ld_n(ld_n), .wr_n(wr_n), .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3),
        .addr(addr), .bwe_n(bwe_n), .oe_n(oe_n), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    always #2 clk = ~clk;

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    function automatic logic [DW-1:0] pat(int a, int k);
        return DW'(a * 36'h1_3579_BDF1) ^ DW'(k * 36'h9_2468_ACE3) ^ DW'(a << 20);
    endfunction

    task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // One clock cycle: csp 0 = all enables true, 1/2/3 = that enable false.
    task automatic step(bit ld, bit wr, int csp, bit cen, bit sl,
                        logic [NL-1:0] be, logic [AW-1:0] a,
                        logic [DW-1:0] d, bit oe, string tag);
        bit go_m;
        bit sel;
        ld_n   = ld;
        wr_n   = wr;
        cs1_n  = (csp == 1);
        cs2_n  = (csp == 2);
        cs3    = (csp != 3);
        cken_n = cen;
        sleep  = sl;
        bwe_n  = be;
        addr   = a;
        oe_n   = oe;
        din    = (m2op == 2) ? m2d : (DW'(36'h5A5A5A5A5) ^ DW'(cyc));
        @(posedge clk);
        cyc++;
        go_m = !cen && !sl;
        if (go_m) begin
            if (m2op == 2)
                for (int k = 0; k < NL; k++)
                    if (!m2b[k]) mm[m2a][k*LW +: LW] = din[k*LW +: LW];
            if (m2op == 1) begin
                exp_dat = mm[m2a];
                exp_drv = 1;
            end else begin
                exp_drv = 0;
            end
            m2op = m1op; m2a = m1a; m2b = m1b; m2d = m1d;
            sel = (csp == 0);
            if (!ld) begin
                m1op = sel ? (wr ? 1 : 2) : 0;
                live = sel;
                if (sel) lwr = !wr;
            end else begin
                m1op = live ? (lwr ? 2 : 1) : 0;
            end
            m1a = a; m1b = be; m1d = d;
        end
        @(negedge clk);
        chk({tag, " dout_en"}, DW'(dout_en), DW'(exp_drv && !oe));
        if (exp_drv && !oe) chk({tag, " dout"}, dout, exp_dat);
    endtask

    task automatic wr_cmd(int a, logic [DW-1:0] d, logic [NL-1:0] be, string tag);
        step(0, 0, 0, 0, 0, be, AW'(a), d, 0, tag);
    endtask
    task automatic rd_cmd(int a, logic [NL-1:0] be, string tag);
        step(0, 1, 0, 0, 0, be, AW'(a), '0, 0, tag);
    endtask
    task automatic idle(string tag);
        step(0, 1, 1, 0, 0, '1, '0, '0, 0, tag);
    endtask

    initial begin
        // Reset: several edges with rst_n low, inputs deselected.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset dout_en", DW'(dout_en), '0);
        rst_n = 1'b1;

        // R6/R1: fill every address with all lanes, back to back.
        for (int a = 0; a < (1 << AW); a++) wr_cmd(a, pat(a, 0), 4'b0000, "R6 fill");
        idle("R5 after write"); idle("R5 after write");
        // R1/R7: read all addresses back to back, byte enables varied.
        for (int a = 0; a < (1 << AW); a++) rd_cmd(a, 4'(a), "R1 R7 read sweep");
        idle("R5 idle"); idle("R5 idle");

        // R6: every lane combination on addresses 0..15.
        for (int a = 0; a < 16; a++) wr_cmd(a, pat(a, 1), 4'(a), "R6 lane write");
        for (int a = 0; a < 16; a++) rd_cmd(a, 4'b0000, "R6 lane read");
        // R7: repeat reads to confirm reads left the array untouched.
        for (int a = 0; a < 16; a++) rd_cmd(a, 4'(15 - a), "R7 reread");
        idle("R5"); idle("R5");

        // R10: write then read same address on the next edge.
        for (int i = 0; i < 8; i++) begin
            wr_cmd(20 + i, pat(i, 2), 4'(i * 3), "R10 write");
            rd_cmd(20 + i, 4'b0000, "R10 read");
        end
        idle("R5"); idle("R5");

        // R3/R4: read, then deselect writes with each enable false.
        for (int c = 1; c <= 3; c++) begin
            rd_cmd(30, 4'b0000, "R4 read before deselect");
            step(0, 0, c, 0, 0, 4'b0000, 6'd30, pat(c, 3), 0, "R3 R4 deselect write");
            idle("R5 after deselect");
        end
        idle("R5"); idle("R5");
        rd_cmd(30, 4'b1111, "R3 unchanged");
        wr_cmd(31, pat(7, 4), 4'b0000, "R5 write");
        rd_cmd(31, 4'b1111, "R10");
        idle("R5"); idle("R5"); idle("R5");

        // R2: stall mid-pipeline with a write command presented.
        rd_cmd(40, 4'b1111, "R2 read");
        rd_cmd(41, 4'b1111, "R2 read");
        for (int s = 0; s < 3; s++)
            step(0, 0, 0, 1, 0, 4'b0000, 6'd40, pat(s, 5), 0, "R2 stall");
        idle("R2 resume"); idle("R2 resume"); idle("R2 resume");
        rd_cmd(40, 4'b1111, "R2 array kept");
        idle("R5"); idle("R5");

        // R11: sleep with write commands presented.
        wr_cmd(42, pat(1, 6), 4'b0000, "R11 write");
        for (int s = 0; s < 4; s++)
            step(0, 0, 0, 0, 1, 4'b0000, 6'd42, pat(s, 7), 0, "R11 sleep");
        idle("R11 wake"); idle("R11 wake");
        rd_cmd(42, 4'b1111, "R11 array kept");
        idle("R5"); idle("R5");

        // R8: oe_n high masks the read, pipeline keeps going.
        rd_cmd(43, 4'b1111, "R8 read");
        rd_cmd(44, 4'b1111, "R8 read");
        step(0, 1, 1, 0, 0, '1, '0, '0, 1, "R8 masked");
        step(0, 1, 1, 0, 0, '1, '0, '0, 0, "R8 unmasked next read");
        #0.5 oe_n = 1'b1;
        #0.2 chk("R8 async mask", DW'(dout_en), '0);
        oe_n = 1'b0;
        #0.2 chk("R8 async unmask", DW'(dout_en), DW'(exp_drv));
        idle("R5"); idle("R5");

        // R12: advance reads ignore wr_n and chip enables.
        rd_cmd(50, 4'b0000, "R12 load read");
        for (int a = 51; a < 54; a++)
            step(1, 0, 1, 0, 0, 4'b0000, AW'(a), pat(a, 8), 0, "R12 advance read");
        wr_cmd(54, pat(54, 9), 4'b0000, "R12 load write");
        for (int a = 55; a < 58; a++)
            step(1, 1, 3, 0, 0, 4'(a), AW'(a), pat(a, 9), 0, "R12 advance write");
        idle("R12 deselect");
        step(1, 0, 0, 0, 0, 4'b0000, 6'd58, pat(58, 10), 0, "R12 advance after deselect");
        idle("R5"); idle("R5");
        for (int a = 50; a < 59; a++) rd_cmd(a, 4'b1111, "R12 readback");
        idle("R5"); idle("R5");

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule